// File: doc/BRIEF.md
# Serial EEPROM Hub Configuration Loader

This block runs once after reset. It reads a short header from a small three-wire serial EEPROM and turns that header into the configuration that the rest of a USB hub uses: vendor ID, product ID, number of downstream ports, a mask of non-removable ports and the maximum bus-power figure. The EEPROM uses chip select, serial clock, data-in and data-out lines and is word-organised. The block sends one read command for each of the five header words, in address order. The serial clock is derived from the system clock by a parameterised divider.

The header is taken only when an EEPROM answers and its checksum byte matches the identity bytes. In every other case the outputs keep their built-in defaults. Within an accepted header, the port-count and power fields are each range-checked, and a field that is out of range falls back to its own default. When the work is done, a done flag rises and stays high. A present flag tells whether an EEPROM answered. The two amber LED outputs share their pins with the serial lines, so they are enabled only when no EEPROM was found.

Top module: `eeprom_cfg_loader`

## Requirements
- R1: Out of reset, `cfg_done_o` and `ee_present_o` are 0, `amber_en_o` is 0, and every configuration output holds its default: VID 1234h, PID 5678h, 4 ports, mask 0, power 32h.
- R2: For each word address 0 to 4, in that order, `ee_cs` goes high and nine bits go out on `ee_di` (start 1, opcode 1 then 0, then a 6-bit address MSB first). `ee_di` changes only while `ee_sk` is low. `ee_do` is then read as one dummy bit followed by 16 data bits, MSB first. `ee_cs` returns low between words, and `ee_sk` stays low whenever `ee_cs` is low.
- R3: Bits [7:0] of word n hold header byte 2n and bits [15:8] hold byte 2n+1. The byte layout is: 0 = VID low, 1 = VID high, 2 = PID low, 3 = PID high, 4 = checksum, 6 = removable mask, 7 = port count, 8 = power.
- R4: The header is accepted when byte 4 equals (byte0+byte1+byte2+byte3+1) mod 256. In that case VID, PID and mask come from the EEPROM.
- R5: When the checksum does not match, every configuration output keeps its default, and `ee_present_o` is still 1.
- R6: When all five words read as FFFFh, the EEPROM counts as absent: `ee_present_o` is 0, all defaults are kept, and `amber_en_o` is 1 after done.
- R7: In an accepted header, a port count from 1 to 4 is used as given. The values 0 and 5 to 255 give 4.
- R8: In an accepted header, a power byte from 00h to FAh (2 mA units) is used as given. A value above FAh gives the default 32h.
- R9: Bits 1 to 4 of the mask byte map to `nonrem_mask_o[0]` to `[3]` (1 = non-removable). Bits 0, 5, 6 and 7 have no effect.
- R10: `cfg_done_o` rises once after the fifth word and stays high. After that the outputs never change, and `ee_cs` and `ee_sk` stay low.
- R11: `amber_en_o` is 1 only after done with no EEPROM present, and it is never 1 while `ee_cs` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ee_cs | output | 1 | EEPROM chip select, active high |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial command data to the EEPROM |
| ee_do | input | 1 | Serial read data from the EEPROM (pulled high when absent) |
| vid_o | output | 16 | Vendor ID in use |
| pid_o | output | 16 | Product ID in use |
| port_count_o | output | 3 | Number of downstream ports, 1 to 4 |
| nonrem_mask_o | output | 4 | Bit i set: port i+1 has a non-removable device |
| max_pwr_o | output | 8 | Maximum power in 2 mA units |
| cfg_done_o | output | 1 | Loading finished |
| ee_present_o | output | 1 | An EEPROM answered |
| amber_en_o | output | 1 | Amber LEDs on the shared pins may be driven |

## Verification
A bench model of the EEPROM checks each incoming command and replays several header images. The images are:
- a valid header, which proves byte placement and the mask bits that must be ignored;
- the same header with its checksum off by one, which separates acceptance from fallback;
- no EEPROM at all, which separates absence from a bad checksum;
- three more valid headers (all-zero IDs, all-ones IDs whose sum wraps, and mid-range IDs), which probe the port-count and power limits at 0, 1, 4, 5, FAh and FBh.

// File: rtl/eecfg_pkg.sv
// Package for the EEPROM configuration loader.
// Holds the header geometry, the field offsets that the decoder depends on,
// the read-state encoding and the identity checksum function.
package eecfg_pkg;

    localparam int NWORDS = 5;
    localparam int WORD_W = 16;
    localparam int NBYTES = 2 * NWORDS;
    localparam logic [1:0] OP_READ = 2'b10;

    localparam int OFS_VID_LO = 0;
    localparam int OFS_VID_HI = 1;
    localparam int OFS_PID_LO = 2;
    localparam int OFS_PID_HI = 3;
    localparam int OFS_CKSUM  = 4;
    localparam int OFS_MASK   = 6;
    localparam int OFS_PORTS  = 7;
    localparam int OFS_PWR    = 8;

    localparam logic [7:0] PWR_LIMIT = 8'hFA;
    localparam int MAX_PORTS = 4;

    typedef struct packed {
        logic [15:0] vid;
        logic [15:0] pid;
        logic [2:0]  ports;
        logic [3:0]  mask;
        logic [7:0]  pwr;
    } hub_cfg_t;

    typedef enum logic [1:0] {
        RD_START,
        RD_XFER,
        RD_GAP,
        RD_DONE
    } rd_state_e;

    // Expected checksum: the four identity bytes and one, summed modulo 256.
    function automatic logic [7:0] id_sum(input logic [7:0] a, input logic [7:0] b,
                                          input logic [7:0] c, input logic [7:0] d);
        return a + b + c + d + 8'd1;
    endfunction

endpackage

// File: rtl/eecfg_sk_gen.sv
// Serial clock generator.
// While en is high, sk toggles every HALF_DIV system clocks, starting low.
// fall_tick marks the system cycle in which sk goes from high to low.
// Assumes en drops no earlier than the cycle after a fall_tick.
module eecfg_sk_gen #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic sk,
    output logic fall_tick
);
    localparam int CW = $clog2(HALF_DIV + 1);

    logic [CW-1:0] cnt;
    logic          sk_q;
    logic          wrap;

    assign wrap      = (cnt == CW'(HALF_DIV - 1));
    assign fall_tick = en && wrap && sk_q;
    assign sk        = sk_q;

    // Half-period counter and clock toggle; held low when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt  <= '0;
            sk_q <= 1'b0;
        end else if (wrap) begin
            cnt  <= '0;
            sk_q <= ~sk_q;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

    AST_SK_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !sk);  // R2

endmodule

// File: rtl/eecfg_mw_reader.sv
// Serial word reader.
// Reads header words 0..NWORDS-1 in order, one read command per word. The
// command is start 1, opcode 10 and an ADDR_W-bit address, MSB first. Command
// bits change on serial clock falls. Read data is sampled at the end of each
// high phase: one dummy bit and then WORD_W bits, MSB first. Chip select is
// dropped for one serial period between words. done_o pulses once at the end.
module eecfg_mw_reader
    import eecfg_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int HALF_DIV = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     fall_tick,
    input  logic                     ee_do,
    output logic                     ee_cs,
    output logic                     ee_di,
    output logic                     sk_en,
    output logic [NWORDS*WORD_W-1:0] words_o,
    output logic                     done_o
);
    localparam int CMD_W   = 3 + ADDR_W;
    localparam int LAST    = CMD_W + WORD_W - 1;
    localparam int BCW     = $clog2(LAST + 1);
    localparam int GAP_CYC = 2 * HALF_DIV;
    localparam int GCW     = $clog2(GAP_CYC + 1);
    localparam int IW      = $clog2(NWORDS);

    rd_state_e         state;
    logic [CMD_W-1:0]  cmd_sr;
    logic [WORD_W-1:0] data_sr;
    logic [BCW-1:0]    bitcnt;
    logic [GCW-1:0]    gap;
    logic [IW-1:0]     widx;
    logic [WORD_W-1:0] words [NWORDS];

    assign sk_en = (state == RD_XFER);

    // Flatten the stored words, word i at bits [i*WORD_W +: WORD_W].
    for (genvar i = 0; i < NWORDS; i++) begin : g_flat
        assign words_o[i*WORD_W +: WORD_W] = words[i];
    end

    // Sequencer: build the command, shift bits on serial falls, pace the words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= RD_START;
            ee_cs   <= 1'b0;
            ee_di   <= 1'b0;
            cmd_sr  <= '0;
            data_sr <= '0;
            bitcnt  <= '0;
            gap     <= '0;
            widx    <= '0;
            done_o  <= 1'b0;
            for (int i = 0; i < NWORDS; i++) words[i] <= '0;
        end else begin
            done_o <= 1'b0;
            case (state)
                RD_START: begin
                    cmd_sr <= {1'b1, OP_READ, ADDR_W'(widx)};
                    ee_di  <= 1'b1;
                    ee_cs  <= 1'b1;
                    bitcnt <= '0;
                    state  <= RD_XFER;
                end
                RD_XFER: begin
                    if (fall_tick) begin
                        bitcnt <= bitcnt + BCW'(1);
                        if (bitcnt < BCW'(CMD_W - 1)) begin
                            ee_di  <= cmd_sr[CMD_W-2];
                            cmd_sr <= cmd_sr << 1;
                        end else begin
                            ee_di <= 1'b0;
                        end
                        if (bitcnt >= BCW'(CMD_W)) begin
                            data_sr <= {data_sr[WORD_W-2:0], ee_do};
                        end
                        if (bitcnt == BCW'(LAST)) begin
                            words[widx] <= {data_sr[WORD_W-2:0], ee_do};
                            ee_cs       <= 1'b0;
                            gap         <= '0;
                            state       <= RD_GAP;
                        end
                    end
                end
                RD_GAP: begin
                    if (gap == GCW'(GAP_CYC - 1)) begin
                        if (widx == IW'(NWORDS - 1)) begin
                            state  <= RD_DONE;
                            done_o <= 1'b1;
                        end else begin
                            widx  <= widx + IW'(1);
                            state <= RD_START;
                        end
                    end else begin
                        gap <= gap + GCW'(1);
                    end
                end
                default: begin
                    ee_cs <= 1'b0;
                end
            endcase
        end
    end

    AST_XFER_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        sk_en |-> ee_cs);  // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);  // R10

endmodule

// File: rtl/eecfg_decode.sv
// Header decoder, combinational.
// Splits the flat words into header bytes (low byte first) and judges whether
// an EEPROM answered and whether the checksum holds. It then range-checks the
// port-count and power fields and substitutes the defaults wherever required.
module eecfg_decode
    import eecfg_pkg::*;
#(
    parameter logic [15:0] DEF_VID   = 16'h1234,
    parameter logic [15:0] DEF_PID   = 16'h5678,
    parameter logic [2:0]  DEF_PORTS = 3'd4,
    parameter logic [3:0]  DEF_MASK  = 4'h0,
    parameter logic [7:0]  DEF_PWR   = 8'h32
) (
    input  logic [NWORDS*WORD_W-1:0] words_i,
    output hub_cfg_t                 cfg_o,
    output logic                     present_o
);
    logic [7:0] hb [NBYTES];
    logic       accept;
    logic       ports_ok;
    logic       pwr_ok;

    // Byte k of the header sits at bits [k*8 +: 8] of the flat words.
    for (genvar k = 0; k < NBYTES; k++) begin : g_bytes
        assign hb[k] = words_i[k*8 +: 8];
    end

    // Presence, checksum and field range judgements.
    always_comb begin
        present_o = |(~words_i);
        accept    = present_o && (hb[OFS_CKSUM] ==
                    id_sum(hb[OFS_VID_LO], hb[OFS_VID_HI], hb[OFS_PID_LO], hb[OFS_PID_HI]));
        ports_ok  = (hb[OFS_PORTS] >= 8'd1) && (hb[OFS_PORTS] <= 8'(MAX_PORTS));
        pwr_ok    = (hb[OFS_PWR] <= PWR_LIMIT);
    end

    // Field selection between header contents and defaults.
    always_comb begin
        cfg_o.vid   = DEF_VID;
        cfg_o.pid   = DEF_PID;
        cfg_o.ports = DEF_PORTS;
        cfg_o.mask  = DEF_MASK;
        cfg_o.pwr   = DEF_PWR;
        if (accept) begin
            cfg_o.vid  = {hb[OFS_VID_HI], hb[OFS_VID_LO]};
            cfg_o.pid  = {hb[OFS_PID_HI], hb[OFS_PID_LO]};
            cfg_o.mask = hb[OFS_MASK][4:1];
            if (ports_ok) cfg_o.ports = hb[OFS_PORTS][2:0];
            if (pwr_ok)   cfg_o.pwr   = hb[OFS_PWR];
        end
    end

endmodule

// File: rtl/eeprom_cfg_loader.sv
// EEPROM configuration loader, top level.
// Runs the serial reader once after reset. When the reader finishes, it
// captures the decoded configuration, and from then on it holds that
// configuration and the done and present flags until the next reset.
// Assumes the data line is pulled high when no EEPROM is fitted.
module eeprom_cfg_loader
    import eecfg_pkg::*;
#(
    parameter int          ADDR_W    = 6,
    parameter int          HALF_DIV  = 4,
    parameter logic [15:0] DEF_VID   = 16'h1234,
    parameter logic [15:0] DEF_PID   = 16'h5678,
    parameter logic [2:0]  DEF_PORTS = 3'd4,
    parameter logic [3:0]  DEF_MASK  = 4'h0,
    parameter logic [7:0]  DEF_PWR   = 8'h32
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic        ee_cs,
    output logic        ee_sk,
    output logic        ee_di,
    input  logic        ee_do,
    output logic [15:0] vid_o,
    output logic [15:0] pid_o,
    output logic [2:0]  port_count_o,
    output logic [3:0]  nonrem_mask_o,
    output logic [7:0]  max_pwr_o,
    output logic        cfg_done_o,
    output logic        ee_present_o,
    output logic        amber_en_o
);
    logic                     sk_en;
    logic                     fall_tick;
    logic                     rd_done;
    logic [NWORDS*WORD_W-1:0] words;
    hub_cfg_t                 dec_cfg;
    logic                     dec_present;

    eecfg_sk_gen #(.HALF_DIV(HALF_DIV)) u_skgen (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (sk_en),
        .sk        (ee_sk),
        .fall_tick (fall_tick)
    );

    eecfg_mw_reader #(.ADDR_W(ADDR_W), .HALF_DIV(HALF_DIV)) u_reader (
        .clk       (clk),
        .rst_n     (rst_n),
        .fall_tick (fall_tick),
        .ee_do     (ee_do),
        .ee_cs     (ee_cs),
        .ee_di     (ee_di),
        .sk_en     (sk_en),
        .words_o   (words),
        .done_o    (rd_done)
    );

    eecfg_decode #(
        .DEF_VID   (DEF_VID),
        .DEF_PID   (DEF_PID),
        .DEF_PORTS (DEF_PORTS),
        .DEF_MASK  (DEF_MASK),
        .DEF_PWR   (DEF_PWR)
    ) u_decode (
        .words_i   (words),
        .cfg_o     (dec_cfg),
        .present_o (dec_present)
    );

    // Configuration registers: defaults in reset, captured once on reader done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vid_o         <= DEF_VID;
            pid_o         <= DEF_PID;
            port_count_o  <= DEF_PORTS;
            nonrem_mask_o <= DEF_MASK;
            max_pwr_o     <= DEF_PWR;
            cfg_done_o    <= 1'b0;
            ee_present_o  <= 1'b0;
        end else if (rd_done && !cfg_done_o) begin
            vid_o         <= dec_cfg.vid;
            pid_o         <= dec_cfg.pid;
            port_count_o  <= dec_cfg.ports;
            nonrem_mask_o <= dec_cfg.mask;
            max_pwr_o     <= dec_cfg.pwr;
            cfg_done_o    <= 1'b1;
            ee_present_o  <= dec_present;
        end
    end

    // The shared amber pins are free only once loading found no EEPROM.
    assign amber_en_o = cfg_done_o && !ee_present_o;

    AST_SK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        !ee_cs |-> !ee_sk);  // R2
    AST_DI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_sk && $past(ee_sk)) |-> $stable(ee_di));  // R2
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done_o |=> cfg_done_o);  // R10
    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_done_o && $past(cfg_done_o)) |-> ($stable(vid_o) && $stable(pid_o) && $stable(max_pwr_o)));  // R10
    AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done_o |-> (!ee_cs && !ee_sk));  // R10
    AST_PORTS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (port_count_o >= 3'd1) && (port_count_o <= 3'(MAX_PORTS)));  // R7
    AST_PWR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        max_pwr_o <= PWR_LIMIT);  // R8
    AST_AMBER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ee_cs |-> !amber_en_o);  // R11
    AST_PRESENT_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        ee_present_o |-> cfg_done_o);  // R1

endmodule

// File: tb/sim_eeprom_cfg_loader.sv
// Directed bench: a behavioural EEPROM model plus one task per header image.
module sim_eeprom_cfg_loader;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ee_cs, ee_sk, ee_di, ee_do;
    logic [15:0] vid_o, pid_o;
    logic [2:0]  port_count_o;
    logic [3:0]  nonrem_mask_o;
    logic [7:0]  max_pwr_o;
    logic cfg_done_o, ee_present_o, amber_en_o;

    int nchk = 0;
    int nfail = 0;

    always #10 clk = ~clk;  // 50 MHz

    eeprom_cfg_loader u0 (
        .clk(clk), .rst_n(rst_n), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di),
        .ee_do(ee_do), .vid_o(vid_o), .pid_o(pid_o), .port_count_o(port_count_o),
        .nonrem_mask_o(nonrem_mask_o), .max_pwr_o(max_pwr_o), .cfg_done_o(cfg_done_o),
        .ee_present_o(ee_present_o), .amber_en_o(amber_en_o)
    );

    // EEPROM model: five words, pulled-high data line when not fitted.
    logic [15:0] img [5];
    logic        fitted = 1'b1;
    logic        do_q = 1'b1;
    logic [8:0]  cmd = '0;
    int          k = 0;
    int          ncmd = 0;
    int          cmd_err = 0;

    assign ee_do = fitted ? do_q : 1'b1;

    always @(posedge ee_sk or negedge ee_cs) begin
        if (!ee_cs) begin
            k = 0;
            do_q = 1'b1;
        end else begin
            if (k < 9) cmd = {cmd[7:0], ee_di};
            if (k == 8) begin
                if (cmd[8:6] != 3'b110 || cmd[5:0] != 6'(ncmd % 5)) cmd_err++;
                ncmd++;
                do_q = 1'b0;
            end else if (k >= 9 && k <= 24) begin
                do_q = (cmd[5:0] < 6'd5) ? img[cmd[5:0]][24-k] : 1'b1;
            end
            k++;
        end
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic load(input logic [15:0] w0, input logic [15:0] w1, input logic [15:0] w2,
                        input logic [15:0] w3, input logic [15:0] w4, input logic fit);
        int base_cmd;
        int base_err;
        img[0] = w0; img[1] = w1; img[2] = w2; img[3] = w3; img[4] = w4;
        fitted = fit;
        base_cmd = ncmd;
        base_err = cmd_err;
        @(negedge clk); rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        for (int t = 0; t < 5000 && !cfg_done_o; t++) @(negedge clk);
        chk("R10 done reached", 16'(cfg_done_o), 16'd1);
        if (fit) begin
            chk("R2 commands issued", 16'(ncmd - base_cmd), 16'd5);
            chk("R2 command format", 16'(cmd_err - base_err), 16'd0);
        end
    endtask

    task automatic expect_cfg(input string tag, input logic [15:0] v, input logic [15:0] p,
                              input logic [2:0] n, input logic [3:0] m, input logic [7:0] w,
                              input logic pres);
        chk({tag, " VID"}, vid_o, v);
        chk({tag, " PID"}, pid_o, p);
        chk({tag, " ports"}, 16'(port_count_o), 16'(n));
        chk({tag, " mask"}, 16'(nonrem_mask_o), 16'(m));
        chk({tag, " power"}, 16'(max_pwr_o), 16'(w));
        chk({tag, " present"}, 16'(ee_present_o), 16'(pres));
        chk("R11 amber enable", 16'(amber_en_o), 16'(!pres));
    endtask

    task automatic t_reset;
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 done", 16'(cfg_done_o), 16'd0);
        chk("R1 present", 16'(ee_present_o), 16'd0);
        chk("R1 amber", 16'(amber_en_o), 16'd0);
        chk("R1 VID", vid_o, 16'h1234);
        chk("R1 ports", 16'(port_count_o), 16'd4);
        chk("R1 power", 16'(max_pwr_o), 16'h32);
    endtask

    task automatic t_valid;  // R3 R4 R9: checksum CD+AB+23+01+1 = 9D, mask E5 -> 0010
        load(16'hABCD, 16'h0123, 16'hFF9D, 16'h03E5, 16'hFF64, 1'b1);
        expect_cfg("R4", 16'hABCD, 16'h0123, 3'd3, 4'b0010, 8'h64, 1'b1);
        repeat (100) @(negedge clk);
        chk("R10 held VID", vid_o, 16'hABCD);
        chk("R10 cs idle", 16'(ee_cs), 16'd0);
        chk("R10 sk idle", 16'(ee_sk), 16'd0);
    endtask

    task automatic t_badsum;  // R5
        load(16'hABCD, 16'h0123, 16'hFF9E, 16'h03E5, 16'hFF64, 1'b1);
        expect_cfg("R5", 16'h1234, 16'h5678, 3'd4, 4'h0, 8'h32, 1'b1);
    endtask

    task automatic t_absent;  // R6
        load(16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 1'b0);
        expect_cfg("R6", 16'h1234, 16'h5678, 3'd4, 4'h0, 8'h32, 1'b0);
    endtask

    task automatic t_zero_ports;  // R7 port 0, R8 power FB, R9 mask 1E -> 1111
        load(16'h0000, 16'h0000, 16'hFF01, 16'h001E, 16'hFFFB, 1'b1);
        expect_cfg("R7R8", 16'h0000, 16'h0000, 3'd4, 4'b1111, 8'h32, 1'b1);
    endtask

    task automatic t_wrap;  // R4 sum wraps to FD, R7 port 1, R8 power FA, R9 mask E1 -> 0000
        load(16'hFFFF, 16'hFFFF, 16'hFFFD, 16'h01E1, 16'hFFFA, 1'b1);
        expect_cfg("R7R8R9", 16'hFFFF, 16'hFFFF, 3'd1, 4'b0000, 8'hFA, 1'b1);
    endtask

    task automatic t_five_ports;  // R7 port 5 -> 4, R8 power 00, port 4 via separate image
        load(16'h1111, 16'h2222, 16'hFF67, 16'h0500, 16'hFF00, 1'b1);
        expect_cfg("R7", 16'h1111, 16'h2222, 3'd4, 4'h0, 8'h00, 1'b1);
        load(16'h1111, 16'h2222, 16'hFF67, 16'h0400, 16'hFF00, 1'b1);
        chk("R7 four ports", 16'(port_count_o), 16'd4);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL R10 watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        t_reset();
        t_valid();
        t_badsum();
        t_absent();
        t_zero_ports();
        t_wrap();
        t_five_ports();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule